// File: doc/BRIEF.md
# Spike-Rate Pixel Integrator

This block turns a stream of address events into an image of per-pixel activity. Each clock cycle may carry one spike, given as a row address and a column address in parallel with a valid strobe. A saturating counter per pixel tallies the spikes that arrive between refreshes. Spikes from a sensor are normally sent grouped by row, but the block accepts any order of addresses.

On each refresh tick a sweep walks every pixel once, in ascending index order, at one pixel per cycle. For each pixel it multiplies the stored value by a fixed decay factor of about 0.914, which is the value of exp(-T/tau) for a 10 ms interval and a 0.111 s time constant. It then adds the spike count weighted by 1/32, writes the result back, and clears that pixel's counter.

A downstream filter reads the image through a registered read port. Pixel values are unsigned, with 4 integer and 12 fractional bits.

Top module: `spike_leak_integrator`

## Requirements
- R1: After reset, every pixel reads 0 and `rdData` is 0.
- R2: `rdData` shows the stored pixel at index `rdAddr` one clock after `rdAddr` is presented. The pixel index is {row, col}, so the row supplies the upper address bits.
- R3: Each cycle with `evValid` high adds one to the spike count of the addressed pixel. Back-to-back cycles each count.
- R4: A spike count saturates at 63 (2^CNT_W-1), so further spikes in the same interval add nothing.
- R5: The clock edge that samples `tick` while the block is idle starts a sweep. Pixel k is rewritten at the (k+1)-th edge after that edge. The sweep covers all pixels in ascending order, one per cycle.
- R6: Each updated pixel becomes floor(old*59891/65536) + n*128, where n is its spike count (1/32 equals 128 in the 12-fraction-bit format).
- R7: A result above 65535 is clamped to 65535.
- R8: A pixel's count is cleared when that pixel is updated, so a pixel with no new spikes only decays on the next refresh.
- R9: A spike for a pixel that arrives in the same cycle that pixel is updated is not added to this result. It becomes the first count of the next interval.
- R10: A `tick` during a sweep is ignored, so no pixel is updated twice in one sweep.
- R11: Cycles with `evValid` low do not change any count, whatever `evRow` and `evCol` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evValid | input | 1 | A spike is present this cycle |
| evRow | input | ROW_W | Row address of the spike |
| evCol | input | COL_W | Column address of the spike |
| tick | input | 1 | Refresh request, sampled at the clock edge |
| rdAddr | input | ROW_W+COL_W | Pixel index to read, {row, col} |
| rdData | output | DATA_W | Pixel value, registered |

## Verification
The assertions check the sweep sequencing on every cycle:
- a tick from idle starts at pixel 0;
- the index steps by one;
- the sweep ends after the last pixel;
- a tick arriving mid-sweep never restarts it;
- the read port holds steady while its address is unchanged and nothing is written.

The arithmetic can only be shown by the bench's scenarios, which compare values read back against a model of the update formula. These scenarios cover decay, weighting, count and pixel saturation, clearing of counts, and the carrying of a spike that collides with its own pixel's update.

// File: rtl/sli_pkg.sv
package sli_pkg;
  // Strobes from the sweep controller to the datapath
  typedef struct packed {
    logic upd;   // a pixel is being rewritten this cycle
    logic last;  // the pixel being rewritten is the final one
  } sweepStrb_t;
endpackage

// File: rtl/sli_update.sv
module sli_update #(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 6,
  parameter int DECAY_W = 16,
  parameter int unsigned DECAY = 59891,
  parameter int SHIFT   = 7
) (
  input  logic [DATA_W-1:0] oldVal,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] newVal
);
  localparam int PROD_W = DATA_W + DECAY_W;
  localparam int SUM_W  = DATA_W + CNT_W + SHIFT + 1;
  localparam logic [SUM_W-1:0] MAXV = SUM_W'({DATA_W{1'b1}});

  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  decayed;
  logic [SUM_W-1:0]  gain;
  logic [SUM_W-1:0]  sum;

  assign prod    = PROD_W'(oldVal) * PROD_W'(DECAY);
  assign decayed = SUM_W'(prod >> DECAY_W);
  assign gain    = SUM_W'(cnt) << SHIFT;
  assign sum     = decayed + gain;
  assign newVal  = (sum > MAXV) ? {DATA_W{1'b1}} : sum[DATA_W-1:0];
endmodule

// File: rtl/sli_ctrl.sv
module sli_ctrl
  import sli_pkg::*;
#(
  parameter int NPIX  = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  output sweepStrb_t       strb,
  output logic [IDX_W-1:0] updIdx
);
  typedef enum logic {IDLE, SWEEP} state_t;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPIX - 1);

  state_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= IDLE;
      updIdx <= '0;
    end else begin
      unique case (state)
        IDLE: if (tick) begin
          state  <= SWEEP;
          updIdx <= '0;
        end
        SWEEP: if (updIdx == LAST_IDX) begin
          state  <= IDLE;
          updIdx <= '0;
        end else begin
          updIdx <= updIdx + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_comb begin
    strb.upd  = (state == SWEEP);
    strb.last = (state == SWEEP) && (updIdx == LAST_IDX);
  end
endmodule

// File: rtl/sli_datapath.sv
module sli_datapath #(
  parameter int ROW_W   = 3,
  parameter int COL_W   = 3,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 6,
  parameter int DECAY_W = 16,
  parameter int unsigned DECAY = 59891,
  parameter int SHIFT   = 7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   evValid,
  input  logic [ROW_W-1:0]       evRow,
  input  logic [COL_W-1:0]       evCol,
  input  logic                   updEn,
  input  logic [ROW_W+COL_W-1:0] updIdx,
  input  logic [ROW_W+COL_W-1:0] rdAddr,
  output logic [DATA_W-1:0]      rdData
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int NPIX  = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  cntMem [NPIX];
  logic [DATA_W-1:0] pixMem [NPIX];
  logic [IDX_W-1:0]  evIdx;
  logic [NPIX-1:0]   evHit;
  logic [NPIX-1:0]   updHit;
  logic [DATA_W-1:0] nextPix;

  assign evIdx = {evRow, evCol};

  // One-hot decode of the spike target and the pixel under update
  for (genvar g = 0; g < NPIX; g++) begin : gDecode
    assign evHit[g]  = evValid && (evIdx == IDX_W'(g));
    assign updHit[g] = updEn && (updIdx == IDX_W'(g));
  end

  sli_update #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .DECAY_W(DECAY_W),
    .DECAY(DECAY), .SHIFT(SHIFT)
  ) uUpd (
    .oldVal(pixMem[updIdx]),
    .cnt   (cntMem[updIdx]),
    .newVal(nextPix)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPIX; i++) begin
        cntMem[i] <= '0;
        pixMem[i] <= '0;
      end
      rdData <= '0;
    end else begin
      for (int i = 0; i < NPIX; i++) begin
        if (updHit[i]) begin
          pixMem[i] <= nextPix;
          // a colliding spike opens the next interval
          cntMem[i] <= evHit[i] ? CNT_W'(1) : '0;
        end else if (evHit[i] && (cntMem[i] != CNT_MAX)) begin
          cntMem[i] <= cntMem[i] + 1'b1;
        end
      end
      rdData <= pixMem[rdAddr];
    end
  end
endmodule

// File: rtl/spike_leak_integrator.sv
module spike_leak_integrator
  import sli_pkg::*;
#(
  parameter int ROW_W   = 3,
  parameter int COL_W   = 3,
  parameter int DATA_W  = 16,
  parameter int FRAC_W  = 12,
  parameter int CNT_W   = 6,
  parameter int GAIN_LOG2 = 5,
  parameter int DECAY_W = 16,
  parameter int unsigned DECAY = 59891
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   evValid,
  input  logic [ROW_W-1:0]       evRow,
  input  logic [COL_W-1:0]       evCol,
  input  logic                   tick,
  input  logic [ROW_W+COL_W-1:0] rdAddr,
  output logic [DATA_W-1:0]      rdData
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int NPIX  = 1 << IDX_W;
  localparam int SHIFT = FRAC_W - GAIN_LOG2;

  sweepStrb_t       strb;
  logic [IDX_W-1:0] updIdx;

  sli_ctrl #(.NPIX(NPIX), .IDX_W(IDX_W)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .tick  (tick),
    .strb  (strb),
    .updIdx(updIdx)
  );

  sli_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .DECAY_W(DECAY_W), .DECAY(DECAY), .SHIFT(SHIFT)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .evValid(evValid),
    .evRow  (evRow),
    .evCol  (evCol),
    .updEn  (strb.upd),
    .updIdx (updIdx),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );
endmodule

// File: rtl/sli_checker.sv
module sli_checker #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              upd,
  input logic              last,
  input logic [IDX_W-1:0]  idx,
  input logic [IDX_W-1:0]  rdAddr,
  input logic [DATA_W-1:0] rdData
);
  AST_SWEEP_START: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !upd) |=> (upd && idx == '0)); // R5

  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (upd && !last) |=> (upd && idx == $past(idx) + 1'b1)); // R5

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (upd && !last && tick) |=> (idx != '0)); // R10

  AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rstN)
    (upd && last) |=> !upd); // R10

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!upd) && $stable(rdAddr)) |=> $stable(rdData)); // R2
endmodule

bind spike_leak_integrator sli_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W)) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .tick  (tick),
  .upd   (strb.upd),
  .last  (strb.last),
  .idx   (updIdx),
  .rdAddr(rdAddr),
  .rdData(rdData)
);

// File: tb/sim_spike_leak_integrator.sv
`timescale 1ns/1ps
module sim_spike_leak_integrator;
  localparam int ROW_W = 3, COL_W = 3, IDX_W = 6, NPIX = 64, DATA_W = 16;
  localparam int CMAX = 63, DEC = 59891, GAIN = 128, PMAX = 65535;

  // stimulus/expected: row, col, spikes sent, expected pixel after one refresh from 0
  localparam int NVEC = 6;
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 1,  128},    // R3 R6 single spike
    '{1, 2, 5,  640},    // R3 back-to-back spikes
    '{7, 7, 63, 8064},   // R4 at the count limit
    '{3, 4, 70, 8064},   // R4 count saturates
    '{5, 1, 0,  0},      // R6 no spikes
    '{6, 3, 17, 2176}    // R6 weighting
  };

  logic clk = 0, rstN = 0, evValid = 0, tick = 0;
  logic [ROW_W-1:0] evRow = '0;
  logic [COL_W-1:0] evCol = '0;
  logic [IDX_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;

  int checks = 0, errors = 0;
  bit done = 0;
  longint model [NPIX];
  int cnt [NPIX];

  always #2.5 clk = ~clk;

  spike_leak_integrator u0 (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evRow(evRow), .evCol(evCol),
    .tick(tick), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic readPix(input int idx, output longint val);
    rdAddr = IDX_W'(idx);
    @(negedge clk);
    val = rdData;
  endtask

  task automatic spikes(input int r, input int c, input int n);
    for (int j = 0; j < n; j++) begin
      evValid = 1; evRow = ROW_W'(r); evCol = COL_W'(c);
      @(negedge clk);
      if (cnt[r*8+c] < CMAX) cnt[r*8+c]++;
    end
    evValid = 0;
  endtask

  function automatic void modelRefresh();
    for (int i = 0; i < NPIX; i++) begin
      model[i] = ((model[i] * DEC) >> 16) + cnt[i] * GAIN;
      if (model[i] > PMAX) model[i] = PMAX;
      cnt[i] = 0;
    end
  endfunction

  // optional spike into pixel k in the very cycle it is rewritten
  task automatic refresh(input bit collide, input int k);
    tick = 1;
    @(negedge clk);
    tick = 0;
    if (collide) begin
      repeat (k) @(negedge clk);
      evValid = 1; evRow = ROW_W'(k / 8); evCol = COL_W'(k % 8);
      @(negedge clk);
      evValid = 0;
      repeat (NPIX - k) @(negedge clk);
    end else begin
      repeat (NPIX + 1) @(negedge clk);
    end
    modelRefresh();
    if (collide) cnt[k] = 1;
  endtask

  task automatic checkAll(input string req);
    longint v;
    for (int i = 0; i < NPIX; i++) begin
      readPix(i, v);
      check(req, v, model[i]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    longint v;
    for (int i = 0; i < NPIX; i++) begin model[i] = 0; cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdData", rdData, 0);
    readPix(0, v);  check("R1 pix0", v, 0);
    readPix(9, v);  check("R1 pix9", v, 0);
    readPix(63, v); check("R1 pix63", v, 0);

    // table-driven first interval
    for (int t = 0; t < NVEC; t++) spikes(VEC[t][0], VEC[t][1], VEC[t][2]);
    // R11 invalid cycles aimed at pixel (2,2)
    evValid = 0; evRow = 3'd2; evCol = 3'd2;
    repeat (5) @(negedge clk);
    refresh(0, 0);
    for (int t = 0; t < NVEC; t++) begin
      readPix(VEC[t][0] * 8 + VEC[t][1], v);
      check("R6 vector", v, VEC[t][2] > 0 ? VEC[t][3] : 0);
    end
    readPix(2 * 8 + 2, v); check("R11 invalid ignored", v, 0);
    // R2 index is {row,col}: pixel (1,2) at index 10
    readPix(10, v); check("R2 row-major index", v, 640);

    // R8 decay only, counts cleared by last refresh
    refresh(0, 0);
    checkAll("R8 decay only");

    // R9 spike colliding with pixel 20's update
    spikes(0, 0, 3);
    refresh(1, 20);
    checkAll("R9 collision not in current");
    refresh(0, 0);
    checkAll("R9 collision carried");

    // R10 tick mid-sweep ignored
    spikes(0, 0, 4);
    tick = 1; @(negedge clk); tick = 0;
    repeat (20) @(negedge clk);
    tick = 1; @(negedge clk); tick = 0;
    repeat (NPIX - 20 + 2 * NPIX) @(negedge clk);
    modelRefresh();
    checkAll("R10 single sweep");

    // R7 pixel saturation on (0,1) under sustained maximum rate
    for (int it = 0; it < 20; it++) begin
      spikes(0, 1, 63);
      refresh(0, 0);
    end
    readPix(1, v);
    check("R7 clamp", v, PMAX);
    check("R7 model reached clamp", model[1], PMAX);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule